// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the extended-capability registers that one physical function uses to host virtual functions. Host software reaches it through a config port. The port carries a dword index, byte enables, write data and a read strobe. The block answers every read with registered data one cycle later. It keeps the virtual-function count, the control bits, the system page size and six shared virtual-function BARs. It filters every write against legality rules. Illegal writes leave the stored value untouched.

The rest of the function gets the results directly. It sees whether VFs are enabled, whether their memory space is live, the programmed and active VF counts, the selected page size and the BAR contents. The routing-ID offset and stride fields are read-only. Their values follow the programmed count and the alternative-routing setting. A synchronous conventional reset and a PF-level function reset both return the whole capability to its power-on state.

Top module: `vfcap_regs`

## Requirements
- R1: After `rst`, the following values hold: control dword 2 reads 0, the count at dword 4 reads 0, the system page at dword 7 reads 1, every BAR reads 0, `vf_count` is 0, `vf_mem_en` is 0 and `sys_page` is 1.
- R2: The read-only dwords ignore writes. Dword 0 reads 0x00010010 (ID 0x0010 in bits 15:0, version 1 in bits 19:16, next pointer 0 in bits 31:20). Dword 1 reads 1 (bit 0 = migration capable). Dword 3 reads TotalVFs 16 in bits 31:16 and InitialVFs 8 in bits 15:0. Dword 6 reads the supported page mask 0x13.
- R3: A count write to dword 4 bits 15:0 is accepted only if the value is at most the current limit. The limit is 16 (TotalVFs) when migration enable (control bit 1) is set, and 8 (InitialVFs) otherwise. A value above the limit is ignored.
- R4: While VF enable (control bit 0) is set, writes to the count and to the system page size are ignored.
- R5: A system page write is accepted only if it has exactly one bit set and that bit is in the supported mask. Any other value is ignored.
- R6: Dword 5 reads the first-VF offset in bits 15:0 and the stride in bits 31:16. Both read 0 while the count is 0. Otherwise they read offset 1 and stride 1, or offset 8 and stride 2 while the routing-extension bit (control bit 4) is set.
- R7: Each BAR at dwords 8 to 13 keeps bits 31:12 of the written value. Bits 11:0 always read 0. The stored value appears on the matching 32-bit slice of `vf_bar`.
- R8: `vf_count` equals the count while VF enable is set and 0 otherwise. `vf_mem_en` is high only when both VF enable and VF memory enable (control bit 3) are set.
- R9: A `pf_flr` cycle returns every register to its reset value. It wins over a config write in the same cycle.
- R10: Read data appears one cycle after `cfg_rd`. Dwords 14 and 15 read 0, and control bits other than 0, 1, 3 and 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous conventional reset, active high |
| pf_flr | input | 1 | PF function-level reset pulse |
| cfg_wr | input | 1 | Config write strobe |
| cfg_rd | input | 1 | Config read strobe |
| cfg_dw | input | 4 | Dword index inside the capability |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read data, valid one cycle after cfg_rd |
| vf_enable | output | 1 | VFs enabled |
| vf_mem_en | output | 1 | VF memory space live |
| num_vfs | output | 16 | Programmed VF count |
| vf_count | output | 16 | VFs currently associated with the PF |
| sys_page | output | 32 | Selected system page size (one-hot) |
| vf_bar | output | 192 | Six VF BAR values, BAR0 in bits 31:0 |

## Verification
A PF function reset and a config write can land on the same clock edge. The reset must win, so none of the written data may survive. The bench provokes this by raising `pf_flr` in the cycle that carries a BAR write. It then reads back that BAR, the count, the control word and the page size, and expects reset values in all of them. Legality filtering and the enable lock also interact. The bench repeats the count and page writes after setting VF enable and expects the earlier values back.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

    localparam int ADDR_W = 4;
    localparam logic [15:0] CAP_ID = 16'h0010;
    localparam logic [3:0]  CAP_VER = 4'h1;

    typedef enum logic [ADDR_W-1:0] {
        DW_HDR    = 4'd0,
        DW_CAPS   = 4'd1,
        DW_CTRL   = 4'd2,
        DW_COUNTS = 4'd3,
        DW_NUM    = 4'd4,
        DW_RID    = 4'd5,
        DW_PGSUP  = 4'd6,
        DW_PGSYS  = 4'd7,
        DW_BAR0   = 4'd8,
        DW_BAR1   = 4'd9,
        DW_BAR2   = 4'd10,
        DW_BAR3   = 4'd11,
        DW_BAR4   = 4'd12,
        DW_BAR5   = 4'd13
    } dw_sel_e;

    typedef struct packed {
        logic ari;
        logic mse;
        logic mig;
        logic en;
    } ctrl_t;

    function automatic logic [31:0] merge_be(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        return r;
    endfunction

    function automatic logic page_ok(input logic [31:0] v, input logic [31:0] sup);
        return ($countones(v) == 1) && ((v & sup) != 32'h0);
    endfunction

endpackage

// File: rtl/vfcap_rid_calc.sv
module vfcap_rid_calc #(
    parameter logic [15:0] FST_STD = 16'd1,
    parameter logic [15:0] STR_STD = 16'd1,
    parameter logic [15:0] FST_ARI = 16'd8,
    parameter logic [15:0] STR_ARI = 16'd2
) (
    input  logic [15:0] num_vfs,
    input  logic        ari,
    output logic [15:0] first_ofs,
    output logic [15:0] stride
);
    always_comb begin
        if (num_vfs == 16'h0) begin
            first_ofs = 16'h0;
            stride    = 16'h0;
        end else if (ari) begin
            first_ofs = FST_ARI;
            stride    = STR_ARI;
        end else begin
            first_ofs = FST_STD;
            stride    = STR_STD;
        end
    end
endmodule

// File: rtl/vfcap_bar_bank.sv
module vfcap_bar_bank #(
    parameter int NUM_BAR   = 6,
    parameter int APER_LOG2 = 12
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [2:0]           idx,
    input  logic [31:0]          wdata,
    input  logic [3:0]           be,
    output logic [NUM_BAR*32-1:0] bars
);
    import vfcap_pkg::*;

    localparam logic [31:0] KEEP = ~((32'h1 << APER_LOG2) - 32'h1);

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
        logic [31:0] q;
        always_ff @(posedge clk) begin
            if (clr)
                q <= 32'h0;
            else if (wr && idx == 3'(i))
                q <= merge_be(q, wdata, be) & KEEP;
        end
        assign bars[i*32 +: 32] = q;

        assert_bar_low_R7: assert property (@(posedge clk)
            (wr && idx == 3'(i)) |=> ((bars[i*32 +: 32] & ~KEEP) == 32'h0));
    end
endmodule

// File: rtl/vfcap_regs.sv
module vfcap_regs #(
    parameter logic [15:0] TOTAL_VF  = 16'd16,
    parameter logic [15:0] INIT_VF   = 16'd8,
    parameter bit          MIG_CAP   = 1'b1,
    parameter logic [31:0] SUP_PG    = 32'h0000_0013,
    parameter logic [11:0] NEXT_PTR  = 12'h000,
    parameter int          NUM_BAR   = 6,
    parameter int          APER_LOG2 = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pf_flr,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    input  logic [3:0]            cfg_dw,
    input  logic [31:0]           cfg_wdata,
    input  logic [3:0]            cfg_be,
    output logic [31:0]           cfg_rdata,
    output logic                  vf_enable,
    output logic                  vf_mem_en,
    output logic [15:0]           num_vfs,
    output logic [15:0]           vf_count,
    output logic [31:0]           sys_page,
    output logic [NUM_BAR*32-1:0] vf_bar
);
    import vfcap_pkg::*;

    localparam logic [15:0] INIT_EFF = MIG_CAP ? INIT_VF : TOTAL_VF;
    localparam int          BAR_LAST = int'(DW_BAR0) + NUM_BAR - 1;

    ctrl_t       ctrl_q;
    logic [15:0] num_q;
    logic [31:0] pg_q;
    logic        clr;
    dw_sel_e     sel;
    logic [31:0] num_new, pg_new;
    logic [15:0] limit;
    logic        bar_hit;
    logic [15:0] first_ofs, stride;
    logic [31:0] rd_mux;

    assign clr   = rst | pf_flr;
    assign sel   = dw_sel_e'(cfg_dw);
    assign limit = ctrl_q.mig ? TOTAL_VF : INIT_EFF;
    assign num_new = merge_be({16'h0, num_q}, cfg_wdata, cfg_be);
    assign pg_new  = merge_be(pg_q, cfg_wdata, cfg_be);
    assign bar_hit = cfg_wr && (int'(cfg_dw) >= int'(DW_BAR0)) && (int'(cfg_dw) <= BAR_LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl_q <= '0;
            num_q  <= 16'h0;
            pg_q   <= 32'h1;
        end else if (cfg_wr) begin
            case (sel)
                DW_CTRL: if (cfg_be[0]) begin
                    ctrl_q.en  <= cfg_wdata[0];
                    ctrl_q.mig <= MIG_CAP & cfg_wdata[1];
                    ctrl_q.mse <= cfg_wdata[3];
                    ctrl_q.ari <= cfg_wdata[4];
                end
                DW_NUM: if (!ctrl_q.en && num_new[15:0] <= limit)
                    num_q <= num_new[15:0];
                DW_PGSYS: if (!ctrl_q.en && page_ok(pg_new, SUP_PG))
                    pg_q <= pg_new;
                default: ;
            endcase
        end
    end

    vfcap_rid_calc u_rid (
        .num_vfs  (num_q),
        .ari      (ctrl_q.ari),
        .first_ofs(first_ofs),
        .stride   (stride)
    );

    vfcap_bar_bank #(.NUM_BAR(NUM_BAR), .APER_LOG2(APER_LOG2)) u_bars (
        .clk  (clk),
        .clr  (clr),
        .wr   (bar_hit),
        .idx  (3'(int'(cfg_dw) - int'(DW_BAR0))),
        .wdata(cfg_wdata),
        .be   (cfg_be),
        .bars (vf_bar)
    );

    always_comb begin
        rd_mux = 32'h0;
        case (sel)
            DW_HDR:    rd_mux = {NEXT_PTR, CAP_VER, CAP_ID};
            DW_CAPS:   rd_mux = {31'h0, MIG_CAP};
            DW_CTRL:   rd_mux = {27'h0, ctrl_q.ari, ctrl_q.mse, 1'b0, ctrl_q.mig, ctrl_q.en};
            DW_COUNTS: rd_mux = {TOTAL_VF, INIT_EFF};
            DW_NUM:    rd_mux = {16'h0, num_q};
            DW_RID:    rd_mux = {stride, first_ofs};
            DW_PGSUP:  rd_mux = SUP_PG;
            DW_PGSYS:  rd_mux = pg_q;
            default:
                if (int'(cfg_dw) >= int'(DW_BAR0) && int'(cfg_dw) <= BAR_LAST)
                    rd_mux = vf_bar[(int'(cfg_dw) - int'(DW_BAR0))*32 +: 32];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_rdata <= 32'h0;
        else if (cfg_rd)
            cfg_rdata <= rd_mux;
    end

    assign vf_enable = ctrl_q.en;
    assign vf_mem_en = ctrl_q.en & ctrl_q.mse;
    assign num_vfs   = num_q;
    assign vf_count  = ctrl_q.en ? num_q : 16'h0;
    assign sys_page  = pg_q;

    assert_num_range_R3: assert property (@(posedge clk) disable iff (rst)
        num_vfs <= TOTAL_VF);
    assert_lock_count_R4: assert property (@(posedge clk) disable iff (rst)
        (vf_enable && !pf_flr) |=> $stable(num_vfs));
    assert_lock_page_R4: assert property (@(posedge clk) disable iff (rst)
        (vf_enable && !pf_flr) |=> $stable(sys_page));
    assert_page_legal_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(sys_page) == 1) && ((sys_page & SUP_PG) != 32'h0));
    assert_flr_clear_R9: assert property (@(posedge clk) disable iff (rst)
        pf_flr |=> (num_vfs == 16'h0 && !vf_enable && vf_count == 16'h0));
endmodule

// File: tb/tb_vfcap_regs.sv
`timescale 1ns/1ps
module tb_vfcap_regs;
    logic         clk = 1'b0;
    logic         rst, pf_flr, cfg_wr, cfg_rd;
    logic [3:0]   cfg_dw, cfg_be;
    logic [31:0]  cfg_wdata, cfg_rdata, sys_page;
    logic         vf_enable, vf_mem_en;
    logic [15:0]  num_vfs, vf_count;
    logic [191:0] vf_bar;

    int n_chk = 0;
    int n_bad = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    vfcap_regs dut (
        .clk(clk), .rst(rst), .pf_flr(pf_flr), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .vf_enable(vf_enable), .vf_mem_en(vf_mem_en), .num_vfs(num_vfs),
        .vf_count(vf_count), .sys_page(sys_page), .vf_bar(vf_bar)
    );

    task automatic judge(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= cfg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) judge(cfg_rdata, 32'hx, "scoreboard underflow");
            else judge(cfg_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [3:0] dw, input logic [31:0] d, input logic [3:0] be = 4'hf);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_wdata = d; cfg_be = be;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] dw, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cfg_rd = 1'b1; cfg_dw = dw;
        @(posedge clk); #1;
        cfg_rd = 1'b0;
    endtask

    task automatic port(input logic [31:0] act, input logic [31:0] exp, input string tag);
        @(negedge clk);
        judge(act, exp, tag);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8ns * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; pf_flr = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
        cfg_dw = 4'h0; cfg_be = 4'h0; cfg_wdata = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(4'd2, 32'h0, "R1 ctrl");
        rd(4'd4, 32'h0, "R1 count");
        rd(4'd7, 32'h1, "R1 page");
        rd(4'd8, 32'h0, "R1 bar0");
        port({16'h0, vf_count}, 32'h0, "R1 vf_count");
        port({31'h0, vf_mem_en}, 32'h0, "R1 vf_mem_en");
        port(sys_page, 32'h1, "R1 sys_page");

        // R2 read-only words
        rd(4'd0, 32'h0001_0010, "R2 header");
        rd(4'd1, 32'h1, "R2 caps");
        rd(4'd3, 32'h0010_0008, "R2 counts");
        rd(4'd6, 32'h13, "R2 supported");
        wr(4'd0, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFF); wr(4'd6, 32'h0);
        rd(4'd0, 32'h0001_0010, "R2 header after write");
        rd(4'd3, 32'h0010_0008, "R2 counts after write");
        rd(4'd6, 32'h13, "R2 supported after write");
        rd(4'd5, 32'h0, "R6 rid with zero count");

        // R3 count limits
        wr(4'd4, 32'd9);  rd(4'd4, 32'd0, "R3 above initial ignored");
        wr(4'd4, 32'd8);  rd(4'd4, 32'd8, "R3 at initial accepted");
        wr(4'd2, 32'h2);
        wr(4'd4, 32'd16); rd(4'd4, 32'd16, "R3 total with migration");
        wr(4'd4, 32'd17); rd(4'd4, 32'd16, "R3 above total ignored");
        wr(4'd2, 32'h0);
        wr(4'd4, 32'd3);  rd(4'd4, 32'd3, "R3 small count");

        // R5 page size legality
        wr(4'd7, 32'h2);  rd(4'd7, 32'h2, "R5 supported page");
        wr(4'd7, 32'h4);  rd(4'd7, 32'h2, "R5 unsupported page ignored");
        wr(4'd7, 32'h3);  rd(4'd7, 32'h2, "R5 multi-bit page ignored");
        wr(4'd7, 32'h10); rd(4'd7, 32'h10, "R5 largest page");
        port(sys_page, 32'h10, "R5 sys_page port");

        // R6 offset and stride
        rd(4'd5, 32'h0001_0001, "R6 rid standard");
        wr(4'd2, 32'h10);
        rd(4'd5, 32'h0002_0008, "R6 rid extended routing");

        // R7 BARs
        wr(4'd8, 32'hFFFF_FFFF);  rd(4'd8, 32'hFFFF_F000, "R7 bar0 aperture");
        wr(4'd13, 32'h1234_5678); rd(4'd13, 32'h1234_5000, "R7 bar5 value");
        port(vf_bar[191:160], 32'h1234_5000, "R7 bar5 port");

        // R8 enable outputs
        wr(4'd2, 32'h19);
        port({16'h0, vf_count}, 32'd3, "R8 vf_count enabled");
        port({31'h0, vf_mem_en}, 32'h1, "R8 mem enabled");
        rd(4'd2, 32'h19, "R8 ctrl readback");
        wr(4'd2, 32'h11);
        port({31'h0, vf_mem_en}, 32'h0, "R8 mem off without mse");

        // R4 lock while enabled
        wr(4'd4, 32'd5); rd(4'd4, 32'd3, "R4 count locked");
        wr(4'd7, 32'h1); rd(4'd7, 32'h10, "R4 page locked");

        // R10 reserved and undecoded
        rd(4'd14, 32'h0, "R10 dword 14");
        rd(4'd15, 32'h0, "R10 dword 15");
        wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, 32'h1B, "R10 reserved control bits");

        // R9 FLR beats same-cycle write
        pf_flr = 1'b1;
        wr(4'd8, 32'hABCD_0000);
        pf_flr = 1'b0;
        rd(4'd8, 32'h0, "R9 bar after flr");
        rd(4'd4, 32'h0, "R9 count after flr");
        rd(4'd2, 32'h0, "R9 ctrl after flr");
        rd(4'd7, 32'h1, "R9 page after flr");
        port({16'h0, vf_count}, 32'h0, "R9 vf_count after flr");

        // R1 conventional reset after programming
        wr(4'd4, 32'd4); wr(4'd2, 32'h9);
        rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
        rd(4'd4, 32'h0, "R1 count after reset");
        port({31'h0, vf_enable}, 32'h0, "R1 enable after reset");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule